// File: doc/BRIEF.md
# ADC Conversion Sequencer with Receive FIFO

The block walks a small table of conversion entries and turns each into one sample. An entry names an analog channel (a 5-bit mux select) and the number of clock cycles the channel is given to settle before conversion. For every entry the sequencer drives the mux select, counts out the settle window, pulses a start to the converter and pushes the returned 12-bit result into a 16-deep receive FIFO. Entries are packed two per 32-bit table word and are written through a single write port whose index advances by one word per write.

Software sees plain control strobes and status levels: enable, start, single-shot select, table and pointer resets, FIFO flush and pop, separate clears for the data-available and sequence-error flags, and one mask that silences both interrupt outputs. The converter is a behavioural model inside the block. Its result is the channel number in the top five bits and a 7-bit running conversion count below that. Only the selected resolution's upper bits are kept, so the result is always left-aligned.

Top module: `adc_seq`

## Requirements
- R1: Entries run in index order 0,1,2,… Entry 2k sits in table word k with its mux select at bits 4:0 and its delay at bits 15:5; entry 2k+1 takes bits 20:16 and 31:21 of the same word. While an entry is sampled and converted, mux_sel_o holds that entry's select.
- R2: The 2-bit res_i selects 6, 8, 10 or 12 bits for codes 0 to 3. Each result is {mux select, conversion count mod 128}, where the count is the number of conversions completed since reset. The low (12 − bits) bits of the result are forced to zero.
- R3: last_idx_i holds the entry count minus one (0 means one entry). With single_i=1 the run stops after entry last_idx_i and the pointer wraps to 0. A new run needs start_i to be taken low and then high again. With single_i=0 the run wraps to entry 0 and goes on.
- R4: An entry whose delay is below the resolution's bit count + 2 sets seq_err_o, produces no conversion and stops the run. A delay equal to bits + 2 is accepted. clr_err_i clears the flag.
- R5: When start_i is taken low, the entry in progress completes and pushes its sample, and the sequencer then goes idle. No later entry is started.
- R6: tbl_rst_i returns the table write index to word 0, so the next write replaces word 0. ptr_rst_i returns the sequence pointer to entry 0.
- R7: The FIFO holds 16 samples in arrival order. rd_data_o shows the oldest sample. pop_i removes one sample, a pop on an empty FIFO has no effect, and flush_i empties the FIFO.
- R8: A sample that arrives while the FIFO holds 16 samples is dropped and sets overflow_o. The flag stays set until flush_i.
- R9: data_avail_o is set when a push brings the fill above thresh_i (0 means after one sample). It stays set until clr_data_i.
- R10: mask_all_i forces irq_data_o and irq_err_o low but leaves data_avail_o and seq_err_o unchanged. With the mask low, each interrupt follows its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Block enable; low aborts the sequencer |
| start_i | input | 1 | Run request (level) |
| single_i | input | 1 | 1: single pass over the table, 0: continuous |
| res_i | input | 2 | Resolution code: 0=6, 1=8, 2=10, 3=12 bits |
| last_idx_i | input | 4 | Index of the last entry in use (entry count − 1) |
| thresh_i | input | 4 | FIFO fill threshold minus one |
| tbl_wr_i | input | 1 | Write tbl_wdata_i at the table write index |
| tbl_wdata_i | input | 32 | Table word: two packed entries |
| tbl_rst_i | input | 1 | Reset table write index |
| ptr_rst_i | input | 1 | Reset sequence pointer to entry 0 |
| flush_i | input | 1 | Empty the FIFO, clear overflow |
| pop_i | input | 1 | Remove the oldest sample |
| clr_data_i | input | 1 | Clear data-available flag |
| clr_err_i | input | 1 | Clear sequence-error flag |
| mask_all_i | input | 1 | Suppress both interrupt outputs |
| mux_sel_o | output | 5 | Channel select to the converter |
| conv_start_o | output | 1 | Conversion start pulse |
| rd_data_o | output | 12 | Oldest FIFO sample, left-aligned |
| fifo_count_o | output | 5 | FIFO fill level |
| busy_o | output | 1 | Sequencer sampling or converting |
| data_avail_o | output | 1 | Data-available flag |
| seq_err_o | output | 1 | Sequence-error flag |
| overflow_o | output | 1 | FIFO overflow flag |
| irq_data_o | output | 1 | Data-available interrupt |
| irq_err_o | output | 1 | Sequence-error interrupt |

## Verification
A four-entry table with unequal delays is run single-shot at 12 and at 6 bits. This shows that entries come in order with the right channel, and that the low bits are cut to match the resolution. A two-entry continuous run is stopped part way through: the run must wrap past the last entry, and at most the samples already in flight may arrive after start falls. A table holding one entry at exactly the minimum window and one just below it tells the accepted boundary from the rejected one. A fill-to-threshold run, a manual pop, a flush and a run into a full FIFO cover the threshold, head order and overflow drop.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int MUX_W = 5;
  localparam int DLY_W = 11;
  localparam int SMP_W = 12;
  localparam int TAG_W = SMP_W - MUX_W;

  typedef struct packed {
    logic [DLY_W-1:0] dly;
    logic [MUX_W-1:0] mux;
  } entry_t;

  typedef enum logic [1:0] {S_IDLE, S_SAMPLE, S_CONV} seq_state_e;

  function automatic entry_t pick_entry(logic [31:0] word, logic odd);
    return odd ? entry_t'(word[31:16]) : entry_t'(word[15:0]);
  endfunction

  function automatic logic [3:0] res_bits(logic [1:0] code);
    return 4'd6 + {1'b0, code, 1'b0};
  endfunction
endpackage

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 12,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  input  logic          flush_i,
  input  logic          clr_avail_i,
  input  logic [AW-1:0] thresh_i,
  output logic [W-1:0]  data_o,
  output logic [CW-1:0] count_o,
  output logic          avail_o,
  output logic          ovf_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] count_q, count_n;
  logic          full, empty, do_pop, do_push;
  logic          avail_q, ovf_q;

  assign full    = (count_q == CW'(DEPTH));
  assign empty   = (count_q == '0);
  assign do_pop  = pop_i && !empty;
  assign do_push = push_i && (!full || do_pop);
  assign count_n = count_q + CW'(do_push) - CW'(do_pop);

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0; rd_q <= '0; count_q <= '0;
      avail_q <= 1'b0; ovf_q <= 1'b0;
    end else begin
      if (flush_i) begin
        wr_q <= '0; rd_q <= '0; count_q <= '0; ovf_q <= 1'b0;
      end else begin
        if (do_push) wr_q <= nxt(wr_q);
        if (do_pop)  rd_q <= nxt(rd_q);
        count_q <= count_n;
        if (push_i && full && !do_pop) ovf_q <= 1'b1;
      end
      // a crossing push in the same cycle wins over the clear
      if (!flush_i && do_push && (count_n > CW'(thresh_i))) avail_q <= 1'b1;
      else if (clr_avail_i) avail_q <= 1'b0;
    end
  end

  assign data_o  = mem_q[rd_q];
  assign count_o = count_q;
  assign avail_o = avail_q;
  assign ovf_o   = ovf_q;

  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
  p_flush_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_q == '0) && !ovf_q);
  p_empty_pop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty && !push_i && !flush_i) |=> (count_q == '0));
  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !pop_i && !flush_i) |=> ((count_q == CW'(DEPTH)) && ovf_q));
  p_ovf_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !flush_i) |=> ovf_q);
endmodule

// File: rtl/adc_seq_conv_stub.sv
module adc_seq_conv_stub
  import adc_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [MUX_W-1:0] mux_i,
  input  logic [1:0]       res_i,
  output logic             done_o,
  output logic [SMP_W-1:0] sample_o
);
  logic             busy_q, done_q;
  logic [3:0]       cnt_q;
  logic [MUX_W-1:0] mux_q;
  logic [1:0]       res_q;
  logic [TAG_W-1:0] tag_q;
  logic [SMP_W-1:0] smp_q, keep;

  assign keep = {SMP_W{1'b1}} << (SMP_W - int'(res_bits(res_q)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; done_q <= 1'b0; cnt_q <= '0;
      mux_q <= '0; res_q <= '0; tag_q <= '0; smp_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          cnt_q  <= res_bits(res_i) - 4'd1;
          mux_q  <= mux_i;
          res_q  <= res_i;
        end
      end else if (cnt_q == '0) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        smp_q  <= {mux_q, tag_q} & keep;
        tag_q  <= tag_q + 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign done_o   = done_q;
  assign sample_o = smp_q;

  p_start_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int TBL_WORDS = 8,
  localparam int ENT      = 2 * TBL_WORDS,
  localparam int EW       = $clog2(ENT),
  localparam int WW       = $clog2(TBL_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             start_i,
  input  logic             single_i,
  input  logic [1:0]       res_i,
  input  logic [EW-1:0]    last_idx_i,
  input  logic             tbl_wr_i,
  input  logic [31:0]      tbl_wdata_i,
  input  logic             tbl_rst_i,
  input  logic             ptr_rst_i,
  input  logic             clr_err_i,
  input  logic             conv_done_i,
  output logic [MUX_W-1:0] mux_o,
  output logic             conv_start_o,
  output logic             busy_o,
  output logic             err_o
);
  logic [31:0]      tbl_q [TBL_WORDS];
  logic [WW-1:0]    wr_q;
  logic [EW-1:0]    ptr_q;
  seq_state_e       state_q;
  logic [DLY_W-1:0] cnt_q;
  logic [MUX_W-1:0] mux_q;
  logic             start_q, err_q, hold_q;
  entry_t           cur;
  logic             ok_win, launch, advance, at_last;

  assign cur     = pick_entry(tbl_q[ptr_q[EW-1:1]], ptr_q[0]);
  assign ok_win  = cur.dly >= (DLY_W'(res_bits(res_i)) + DLY_W'(2));
  assign launch  = enable_i && start_i && !err_q && !hold_q && (state_q == S_IDLE);
  assign advance = enable_i && (state_q == S_CONV) && conv_done_i;
  assign at_last = ptr_q >= last_idx_i;

  always_ff @(posedge clk_i) begin
    if (tbl_wr_i && !tbl_rst_i) tbl_q[wr_q] <= tbl_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0; ptr_q <= '0; state_q <= S_IDLE; cnt_q <= '0;
      mux_q <= '0; start_q <= 1'b0; err_q <= 1'b0; hold_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (tbl_rst_i)     wr_q <= '0;
      else if (tbl_wr_i) wr_q <= (wr_q == WW'(TBL_WORDS - 1)) ? '0 : wr_q + 1'b1;

      if (!enable_i) begin
        state_q <= S_IDLE;
      end else begin
        unique case (state_q)
          S_IDLE: if (launch && ok_win) begin
            state_q <= S_SAMPLE;
            cnt_q   <= cur.dly - 1'b1;
            mux_q   <= cur.mux;
          end
          S_SAMPLE: if (cnt_q == '0) begin
            state_q <= S_CONV;
            start_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
          S_CONV: if (conv_done_i) state_q <= S_IDLE;
          default: state_q <= S_IDLE;
        endcase
      end

      if (ptr_rst_i)    ptr_q <= '0;
      else if (advance) ptr_q <= at_last ? '0 : EW'(ptr_q + 1'b1);

      if (!start_i)                          hold_q <= 1'b0;
      else if (advance && at_last && single_i) hold_q <= 1'b1;

      if (launch && !ok_win) err_q <= 1'b1;
      else if (clr_err_i)    err_q <= 1'b0;
    end
  end

  assign mux_o        = mux_q;
  assign conv_start_o = start_q;
  assign busy_o       = (state_q != S_IDLE);
  assign err_o        = err_q;

  p_err_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> (state_q == S_IDLE));
  p_mux_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q != S_IDLE) && ($past(state_q) != S_IDLE)) |-> $stable(mux_q));
  p_single_stop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && start_i) |=> (state_q == S_IDLE));
  p_stop_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && (state_q == S_IDLE)) |=> (state_q == S_IDLE));
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int TBL_WORDS  = 8,
  parameter int FIFO_DEPTH = 16,
  localparam int EW        = $clog2(2 * TBL_WORDS),
  localparam int AW        = $clog2(FIFO_DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             start_i,
  input  logic             single_i,
  input  logic [1:0]       res_i,
  input  logic [EW-1:0]    last_idx_i,
  input  logic [AW-1:0]    thresh_i,
  input  logic             tbl_wr_i,
  input  logic [31:0]      tbl_wdata_i,
  input  logic             tbl_rst_i,
  input  logic             ptr_rst_i,
  input  logic             flush_i,
  input  logic             pop_i,
  input  logic             clr_data_i,
  input  logic             clr_err_i,
  input  logic             mask_all_i,
  output logic [MUX_W-1:0] mux_sel_o,
  output logic             conv_start_o,
  output logic [SMP_W-1:0] rd_data_o,
  output logic [AW:0]      fifo_count_o,
  output logic             busy_o,
  output logic             data_avail_o,
  output logic             seq_err_o,
  output logic             overflow_o,
  output logic             irq_data_o,
  output logic             irq_err_o
);
  logic             conv_done;
  logic [SMP_W-1:0] conv_smp;

  adc_seq_ctrl #(.TBL_WORDS(TBL_WORDS)) u_ctrl (
    .clk_i, .rst_ni, .enable_i, .start_i, .single_i, .res_i, .last_idx_i,
    .tbl_wr_i, .tbl_wdata_i, .tbl_rst_i, .ptr_rst_i, .clr_err_i,
    .conv_done_i (conv_done),
    .mux_o       (mux_sel_o),
    .conv_start_o(conv_start_o),
    .busy_o      (busy_o),
    .err_o       (seq_err_o)
  );

  adc_seq_conv_stub u_conv (
    .clk_i, .rst_ni,
    .start_i (conv_start_o),
    .mux_i   (mux_sel_o),
    .res_i   (res_i),
    .done_o  (conv_done),
    .sample_o(conv_smp)
  );

  adc_seq_fifo #(.DEPTH(FIFO_DEPTH), .W(SMP_W)) u_fifo (
    .clk_i, .rst_ni,
    .push_i     (conv_done && enable_i),
    .data_i     (conv_smp),
    .pop_i      (pop_i),
    .flush_i    (flush_i),
    .clr_avail_i(clr_data_i),
    .thresh_i   (thresh_i),
    .data_o     (rd_data_o),
    .count_o    (fifo_count_o),
    .avail_o    (data_avail_o),
    .ovf_o      (overflow_o)
  );

  assign irq_data_o = data_avail_o && !mask_all_i;
  assign irq_err_o  = seq_err_o && !mask_all_i;

  p_mask_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_all_i |-> !(irq_data_o || irq_err_o));
  p_irq_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_data_o |-> data_avail_o);
endmodule

// File: tb/adc_seq_tb_top.sv
module adc_seq_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic enable_i = 0, start_i = 0, single_i = 0;
  logic [1:0] res_i = 0;
  logic [3:0] last_idx_i = 0, thresh_i = 0;
  logic tbl_wr_i = 0, tbl_rst_i = 0, ptr_rst_i = 0, flush_i = 0, pop_i = 0;
  logic clr_data_i = 0, clr_err_i = 0, mask_all_i = 0;
  logic [31:0] tbl_wdata_i = 0;
  logic [4:0] mux_sel_o;
  logic conv_start_o, busy_o, data_avail_o, seq_err_o, overflow_o, irq_data_o, irq_err_o;
  logic [11:0] rd_data_o;
  logic [4:0] fifo_count_o;

  always #5 clk_i = ~clk_i;

  adc_seq dut_i (.*);

  int checks = 0, errors = 0, rx = 0;
  bit done_flag = 0, mon_en = 0, man_pop = 0;
  logic [6:0] cc = 0;
  logic [11:0] exp_q [$];
  string cur = "R0";

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] smp(logic [4:0] m, logic [6:0] c, logic [1:0] r);
    int b = 6 + 2 * r;
    return {m, c} & (12'hFFF << (12 - b));
  endfunction

  function automatic logic [31:0] pack(logic [4:0] m0, logic [10:0] d0, logic [4:0] m1, logic [10:0] d1);
    return {d1, m1, d0, m0};
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk_i); s = 1'b1;
    @(negedge clk_i); s = 1'b0;
  endtask

  task automatic wr_word(logic [31:0] w);
    @(negedge clk_i); tbl_wdata_i = w; tbl_wr_i = 1'b1;
    @(negedge clk_i); tbl_wr_i = 1'b0;
  endtask

  task automatic expect_s(logic [4:0] m, logic [1:0] r);
    exp_q.push_back(smp(m, cc, r));
    cc++;
  endtask

  task automatic wait_drain(string tag);
    int t = 0;
    while ((exp_q.size() != 0) && t < 3000) begin cyc(1); t++; end
    chk({tag, "_drain"}, exp_q.size(), 0);
  endtask

  task automatic wait_count(int n);
    int t = 0;
    while ((fifo_count_o != 5'(n)) && t < 3000) begin cyc(1); t++; end
  endtask

  task automatic stop_run();
    @(negedge clk_i); start_i = 1'b0;
    cyc(2);
  endtask

  // monitor: pops and compares against the scoreboard queue
  initial begin
    forever begin
      @(negedge clk_i);
      if (mon_en && !pop_i && fifo_count_o != 0) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL %s unexpected sample act=%0h exp=none", cur, rd_data_o);
        end else begin
          logic [11:0] e;
          e = exp_q.pop_front();
          if (rd_data_o !== e) begin
            errors++;
            $display("FAIL %s sample act=%0h exp=%0h", cur, rd_data_o, e);
          end
        end
        rx++;
        pop_i = 1'b1;
      end else begin
        pop_i = man_pop;
      end
    end
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    int n0, nd, n;
    cyc(3); rst_ni = 1'b1; cyc(2);
    // reset state
    chk("R7_reset_count", fifo_count_o, 0);
    chk("R9_reset_avail", data_avail_o, 0);
    chk("R4_reset_err", seq_err_o, 0);
    chk("R8_reset_ovf", overflow_o, 0);
    chk("R10_reset_irq", {irq_data_o, irq_err_o}, 0);
    chk("R3_reset_busy", busy_o, 0);

    enable_i = 1;
    wr_word(pack(5'd3, 11'd14, 5'd7, 11'd20));
    wr_word(pack(5'd12, 11'd14, 5'd31, 11'd30));

    // R1 / R3: four entries, 12-bit, single shot
    cur = "R1"; mon_en = 1;
    res_i = 2'd3; last_idx_i = 4'd3; single_i = 1; thresh_i = 4'd15;
    expect_s(3, 3); expect_s(7, 3); expect_s(12, 3); expect_s(31, 3);
    @(negedge clk_i); start_i = 1;
    wait_drain("R1");
    cyc(80);
    chk("R3_single_no_more", fifo_count_o, 0);
    chk("R3_single_idle", busy_o, 0);
    stop_run();

    // R2: 6-bit resolution, two entries
    cur = "R2"; res_i = 2'd0; last_idx_i = 4'd1;
    expect_s(3, 0); expect_s(7, 0);
    @(negedge clk_i); start_i = 1;
    wait_drain("R2");
    cyc(40);
    chk("R2_count_after", fifo_count_o, 0);
    stop_run();

    // R9 / R10 / R7: threshold, mask, manual pop, flush
    cur = "R9"; mon_en = 0; res_i = 2'd3; last_idx_i = 4'd3; thresh_i = 4'd2;
    @(negedge clk_i); start_i = 1;
    wait_count(2);
    chk("R9_below_thresh", data_avail_o, 0);
    wait_count(3);
    chk("R9_at_thresh", data_avail_o, 1);
    chk("R10_irq_follows", irq_data_o, 1);
    mask_all_i = 1; #1;
    chk("R10_mask_irq", irq_data_o, 0);
    chk("R10_mask_flag_kept", data_avail_o, 1);
    mask_all_i = 0;
    wait_count(4);
    cyc(40);
    chk("R3_single_four", fifo_count_o, 4);
    pulse(clr_data_i); cyc(1);
    chk("R9_clear", data_avail_o, 0);
    chk("R7_head", rd_data_o, smp(3, cc, 3));
    @(negedge clk_i); man_pop = 1; @(negedge clk_i); man_pop = 0; cyc(1);
    chk("R7_pop_count", fifo_count_o, 3);
    chk("R7_pop_head", rd_data_o, smp(7, cc + 7'd1, 3));
    cc = cc + 7'd4;
    pulse(flush_i); cyc(1);
    chk("R7_flush", fifo_count_o, 0);
    @(negedge clk_i); man_pop = 1; @(negedge clk_i); man_pop = 0; cyc(1);
    chk("R7_pop_empty", fifo_count_o, 0);
    stop_run();

    // R4: window boundary at 10 bits (min 12)
    cur = "R4"; mon_en = 1; thresh_i = 4'd15;
    pulse(tbl_rst_i);
    wr_word(pack(5'd2, 11'd12, 5'd4, 11'd11));
    pulse(ptr_rst_i);
    res_i = 2'd2; last_idx_i = 4'd1;
    expect_s(2, 2);
    @(negedge clk_i); start_i = 1;
    wait_drain("R4");
    cyc(40);
    chk("R4_err_set", seq_err_o, 1);
    chk("R4_no_conv", fifo_count_o, 0);
    chk("R4_stopped", busy_o, 0);
    chk("R10_irq_err", irq_err_o, 1);
    stop_run();
    mask_all_i = 1; #1;
    chk("R10_mask_err", irq_err_o, 0);
    chk("R10_err_kept", seq_err_o, 1);
    mask_all_i = 0;
    pulse(clr_err_i); cyc(1);
    chk("R4_clear", seq_err_o, 0);

    // R6: pointer reset back to entry 0
    cur = "R6"; pulse(ptr_rst_i);
    last_idx_i = 4'd0;
    expect_s(2, 2);
    @(negedge clk_i); start_i = 1;
    wait_drain("R6_ptr");
    cyc(30);
    chk("R6_no_err", seq_err_o, 0);
    stop_run();

    // R6: table reset rewrites word 0
    pulse(tbl_rst_i);
    wr_word(pack(5'd17, 11'd14, 5'd20, 11'd14));
    pulse(ptr_rst_i);
    res_i = 2'd3; last_idx_i = 4'd1;
    expect_s(17, 3); expect_s(20, 3);
    @(negedge clk_i); start_i = 1;
    wait_drain("R6_tbl");
    stop_run();

    // R3 / R5: continuous with wrap, then stop
    cur = "R5"; pulse(tbl_rst_i);
    wr_word(pack(5'd5, 11'd14, 5'd9, 11'd16));
    single_i = 0; last_idx_i = 4'd1;
    for (int i = 0; i < 12; i++) exp_q.push_back(smp((i % 2) ? 5'd9 : 5'd5, cc + 7'(i), 3));
    n0 = rx;
    @(negedge clk_i); start_i = 1;
    while (rx - n0 < 3) cyc(1);
    nd = rx - n0;
    start_i = 0;
    cyc(100);
    n = rx - n0;
    chk("R3_wrapped", (n >= 3), 1);
    chk("R5_bounded_tail", (n - nd <= 2), 1);
    chk("R5_idle", busy_o, 0);
    chk("R5_fifo_empty", fifo_count_o, 0);
    cc = cc + 7'(n);
    exp_q.delete();

    // R8: overflow in continuous run
    cur = "R8"; mon_en = 0; last_idx_i = 4'd0;
    cyc(2);
    @(negedge clk_i); start_i = 1;
    begin
      int t = 0;
      while (!overflow_o && t < 3000) begin cyc(1); t++; end
    end
    chk("R8_ovf_set", overflow_o, 1);
    chk("R8_full", fifo_count_o, 16);
    start_i = 0;
    cyc(60);
    chk("R8_still_full", fifo_count_o, 16);
    chk("R8_sticky", overflow_o, 1);
    pulse(flush_i); cyc(1);
    chk("R8_flush_clears", overflow_o, 0);
    chk("R7_flush_full", fifo_count_o, 0);

    finish_run();
  end
endmodule